// File: doc/BRIEF.md
# Redundant binary carry-free adder

This block adds two signed-digit numbers of N digits each and returns an N+1 digit signed-digit result. Every digit takes one of the values -1, 0 or +1 and travels on two wires. Each digit position forms an intermediate carry and an intermediate sum from its own pair of input digits. It also inspects the digit pair one position lower, to decide which of two equivalent splits to use. The final digit is the local intermediate sum plus the intermediate carry arriving from directly below. A carry therefore never moves more than one position, and the add time is the same at any width.

A converter to two's complement is part of the block. It gives the numeric value of the redundant result as an ordinary signed binary word, for use by a checker or by a consumer that needs a plain number. The adder itself is purely combinational. It has no state, so there are no states or transitions to name, and the result follows the operands within the same cycle.

Top module: `rb_cf_adder`

## Requirements
- R1: Digit i of an operand or of the result is the bit pair (pos[i], neg[i]) and has the value pos[i] - neg[i]. Code 00 is 0, 10 is +1 and 01 is -1. Code 11 is never used, and operands that contain it give an unspecified result.
- R2: No result digit ever carries code 11, for any legal operands.
- R3: For all legal operands, the value of the result digits, sum over i of 2^i * (sum_pos[i] - sum_neg[i]), equals the value of a plus the value of b.
- R4: The result has N+1 digits. When every operand digit is +1, the result digits are 0 at position 0 and +1 at positions 1..N. When every operand digit is -1, they are 0 at position 0 and -1 at positions 1..N.
- R5: Result digit i depends only on the operand digits at positions i, i-1 and i-2. Changing operand digit 0 leaves result digits 3..N unchanged.
- R6: A digit pair that sums to +1, whose lower neighbour pair contains no -1, splits into carry +1 and sum -1. A pair that sums to -1 under the same condition splits into carry 0 and sum -1. Position 0 behaves as if its lower neighbour contained no -1. With a all +1 and b zero, the result is -1 at digit 0, 0 at digits 1..N-1 and +1 at digit N. With a all -1 and b zero, the result is -1 at digit 0, +1 at digit 1, 0 at digits 2..N-1 and -1 at digit N.
- R7: sum_val, N+2 bits wide, is the two's complement value of the result digits.
- R8: Operands that cancel digit by digit (a all +1, b all -1) give all-zero result digits and sum_val 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_pos | input | N | Positive bits of operand a |
| a_neg | input | N | Negative bits of operand a |
| b_pos | input | N | Positive bits of operand b |
| b_neg | input | N | Negative bits of operand b |
| sum_pos | output | N+1 | Positive bits of the result digits |
| sum_neg | output | N+1 | Negative bits of the result digits |
| sum_val | output | N+2 | Two's complement value of the result |

## Verification
The bench adds every legal pair of 3-digit operands and many random 16-digit pairs, and checks each result value against integer addition. A neighbour rule that picks the wrong split would make a final digit reach +2 or -2. That shows up as a result code 11 or as a wrong value. The bench also checks the exact digit patterns for operands that are all +1, all -1, one-sided and cancelling. These patterns expose a carry that is dropped at the top digit, a split that ignores the lower pair, or a position 0 that assumes a negative neighbour. A locality check changes the lowest operand digit and requires digits 3 and above to stay unchanged, which catches any carry that runs further than one position.

// File: rtl/rb_pkg.sv
package rb_pkg;

    // one signed digit: value is p - n, code 11 unused
    typedef struct packed {
        logic p;
        logic n;
    } rbd_t;

    localparam rbd_t RBD_ZERO = '{p: 1'b0, n: 1'b0};

    function automatic int rbd_val(input rbd_t d);
        return int'(d.p) - int'(d.n);
    endfunction

    function automatic rbd_t rbd_enc(input int v);
        rbd_t d;
        d.p = (v == 1);
        d.n = (v == -1);
        return d;
    endfunction

    function automatic logic rbd_legal(input rbd_t d);
        return !(d.p && d.n);
    endfunction

endpackage

// File: rtl/rb_digit_split.sv
module rb_digit_split
    import rb_pkg::*;
(
    input  rbd_t a_dig,
    input  rbd_t b_dig,
    input  logic lo_nonneg,
    output rbd_t carry_out,
    output rbd_t isum_out
);

    int pair_sum;
    int c_v;
    int s_v;

    always_comb begin
        pair_sum = rbd_val(a_dig) + rbd_val(b_dig);
        c_v = 0;
        s_v = 0;
        unique case (pair_sum)
            2: begin
                c_v = 1;
                s_v = 0;
            end
            1: begin
                if (lo_nonneg) begin
                    c_v = 1;
                    s_v = -1;
                end else begin
                    c_v = 0;
                    s_v = 1;
                end
            end
            -1: begin
                if (lo_nonneg) begin
                    c_v = 0;
                    s_v = -1;
                end else begin
                    c_v = -1;
                    s_v = 1;
                end
            end
            -2: begin
                c_v = -1;
                s_v = 0;
            end
            default: begin
                c_v = 0;
                s_v = 0;
            end
        endcase
        carry_out = rbd_enc(c_v);
        isum_out  = rbd_enc(s_v);
    end

    // checks on the decoded outputs
    always_comb begin
        if (rbd_legal(a_dig) && rbd_legal(b_dig)) begin
            AST_SPLIT_CONSERVES: assert (2 * rbd_val(carry_out) + rbd_val(isum_out)
                                         == rbd_val(a_dig) + rbd_val(b_dig)); // R3
            AST_SPLIT_SIDE: assert (!(lo_nonneg && isum_out.p) && !(!lo_nonneg && isum_out.n)); // R6
        end
    end

endmodule

// File: rtl/rb_digit_merge.sv
module rb_digit_merge
    import rb_pkg::*;
(
    input  rbd_t isum_in,
    input  rbd_t carry_in,
    output rbd_t dig_out
);

    int total;

    always_comb begin
        total   = rbd_val(isum_in) + rbd_val(carry_in);
        dig_out = rbd_enc(total);
    end

    always_comb begin
        if (rbd_legal(isum_in) && rbd_legal(carry_in)) begin
            AST_MERGE_IN_RANGE: assert (rbd_val(isum_in) + rbd_val(carry_in) <= 1 &&
                                        rbd_val(isum_in) + rbd_val(carry_in) >= -1); // R6
        end
    end

endmodule

// File: rtl/rb_to_twos.sv
module rb_to_twos #(
    parameter int W = 17
) (
    input  logic [W-1:0] pos_bits,
    input  logic [W-1:0] neg_bits,
    output logic [W:0]   value
);

    always_comb begin
        value = {1'b0, pos_bits} - {1'b0, neg_bits};
    end

endmodule

// File: rtl/rb_cf_adder.sv
module rb_cf_adder
    import rb_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] a_pos,
    input  logic [N-1:0] a_neg,
    input  logic [N-1:0] b_pos,
    input  logic [N-1:0] b_neg,
    output logic [N:0]   sum_pos,
    output logic [N:0]   sum_neg,
    output logic [N+1:0] sum_val
);

    localparam int RW = N + 1;
    localparam int VW = N + 2;

    rbd_t cy   [N];
    rbd_t isum [N];
    rbd_t dig  [RW];

    for (genvar i = 0; i < N; i++) begin : g_pos
        logic lo_ok;
        if (i == 0) begin : g_first
            assign lo_ok = 1'b1;
        end else begin : g_rest
            assign lo_ok = !(a_neg[i-1] || b_neg[i-1]);
        end

        rb_digit_split u_split (
            .a_dig    ('{p: a_pos[i], n: a_neg[i]}),
            .b_dig    ('{p: b_pos[i], n: b_neg[i]}),
            .lo_nonneg(lo_ok),
            .carry_out(cy[i]),
            .isum_out (isum[i])
        );

        rb_digit_merge u_merge (
            .isum_in (isum[i]),
            .carry_in((i == 0) ? RBD_ZERO : cy[(i == 0) ? 0 : i-1]),
            .dig_out (dig[i])
        );
    end

    assign dig[N] = cy[N-1];

    for (genvar j = 0; j < RW; j++) begin : g_out
        assign sum_pos[j] = dig[j].p;
        assign sum_neg[j] = dig[j].n;
    end

    rb_to_twos #(.W(RW)) u_conv (
        .pos_bits(sum_pos),
        .neg_bits(sum_neg),
        .value   (sum_val)
    );

    logic [VW-1:0] ref_val;
    logic          ops_legal;

    always_comb begin
        ref_val = {2'b00, a_pos} - {2'b00, a_neg} + {2'b00, b_pos} - {2'b00, b_neg};
        ops_legal = ((a_pos & a_neg) == '0) && ((b_pos & b_neg) == '0);
        if (ops_legal) begin
            AST_NO_BOTH_BITS: assert ((sum_pos & sum_neg) == '0); // R2
            AST_VALUE_MATCH: assert (sum_val == ref_val); // R7
        end
    end

endmodule

// File: tb/sim_rb_cf_adder.sv
`timescale 1ns/1ps
module sim_rb_cf_adder;

    localparam int NA = 16;
    localparam int NB = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [NA-1:0] a0p, a0n, b0p, b0n;
    logic [NA:0]   s0p, s0n;
    logic [NA+1:0] s0v;
    logic [NB-1:0] a1p, a1n, b1p, b1n;
    logic [NB:0]   s1p, s1n;
    logic [NB+1:0] s1v;

    rb_cf_adder #(.N(NA)) u0 (.a_pos(a0p), .a_neg(a0n), .b_pos(b0p), .b_neg(b0n),
                              .sum_pos(s0p), .sum_neg(s0n), .sum_val(s0v));
    rb_cf_adder #(.N(NB)) u1 (.a_pos(a1p), .a_neg(a1n), .b_pos(b1p), .b_neg(b1n),
                              .sum_pos(s1p), .sum_neg(s1n), .sum_val(s1v));

    typedef struct {
        int          inst;
        longint      val;
        bit          exact;
        logic [NA:0] epos;
        logic [NA:0] eneg;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    function automatic longint rb_value(input logic [NA:0] p, input logic [NA:0] n, input int w);
        longint v = 0;
        for (int i = 0; i < w; i++) v += (longint'(p[i]) - longint'(n[i])) <<< i;
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input longint got, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, expv);
        end
    endtask

    // driver: apply operands and push the expected item
    task automatic drive(input int inst, input logic [NA-1:0] ap, input logic [NA-1:0] an,
                         input logic [NA-1:0] bp, input logic [NA-1:0] bn, input bit exact,
                         input logic [NA:0] ep, input logic [NA:0] en, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        if (inst == 0) begin
            a0p = ap; a0n = an; b0p = bp; b0n = bn;
        end else begin
            a1p = ap[NB-1:0]; a1n = an[NB-1:0]; b1p = bp[NB-1:0]; b1n = bn[NB-1:0];
        end
        e.inst = inst;
        e.val = rb_value({1'b0, ap}, {1'b0, an}, NA) + rb_value({1'b0, bp}, {1'b0, bn}, NA);
        e.exact = exact;
        e.epos = ep;
        e.eneg = en;
        e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compare at the falling edge
    always @(negedge clk) begin
        if (q.size() != 0) begin
            exp_t e;
            longint gv, dv;
            logic [NA:0] gp, gn;
            int w;
            e = q.pop_front();
            if (e.inst == 0) begin
                w = NA + 1; gp = s0p; gn = s0n; gv = longint'($signed(s0v));
            end else begin
                w = NB + 1; gp = {{(NA-NB){1'b0}}, s1p}; gn = {{(NA-NB){1'b0}}, s1n};
                gv = longint'($signed(s1v));
            end
            dv = rb_value(gp, gn, w);
            check((gp & gn) == '0, {e.tag, " R2 no code 11"}, longint'(gp & gn), 0);
            check(dv == e.val, {e.tag, " R3 digit value"}, dv, e.val);
            check(gv == e.val, {e.tag, " R7 twos value"}, gv, e.val);
            if (e.exact) begin
                check(gp == e.epos, {e.tag, " pos digits"}, longint'(gp), longint'(e.epos));
                check(gn == e.eneg, {e.tag, " neg digits"}, longint'(gn), longint'(e.eneg));
            end
        end
    end

    function automatic void rnd_op(output logic [NA-1:0] p, output logic [NA-1:0] n, input int w);
        p = '0; n = '0;
        for (int i = 0; i < w; i++) begin
            int d = $urandom_range(0, 2);
            p[i] = (d == 1);
            n[i] = (d == 2);
        end
    endfunction

    initial begin
        logic [NA-1:0] ap, an, bp, bn;
        logic [NA:0] keep_p, keep_n;
        localparam logic [NA-1:0] ONES = '1;
        a0p = '0; a0n = '0; b0p = '0; b0n = '0;
        a1p = '0; a1n = '0; b1p = '0; b1n = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // reset state / zero operands: R1 zero code
        drive(0, '0, '0, '0, '0, 1, '0, '0, "R1 zero operands");
        // R4 all +1 and all -1
        drive(0, ONES, '0, ONES, '0, 1, {1'b1, ONES} & ~(NA+1)'(1), '0, "R4 all plus");
        drive(0, '0, ONES, '0, ONES, 1, '0, {1'b1, ONES} & ~(NA+1)'(1), "R4 all minus");
        // R6 one-sided operands
        drive(0, ONES, '0, '0, '0, 1, (NA+1)'(1) << NA, (NA+1)'(1), "R6 a plus b zero");
        drive(0, '0, ONES, '0, '0, 1, (NA+1)'(2), ((NA+1)'(1) << NA) | (NA+1)'(1),
              "R6 a minus b zero");
        // R8 cancelling
        drive(0, ONES, '0, '0, ONES, 1, '0, '0, "R8 cancel");

        // R3 exhaustive at three digits
        for (int x = 0; x < 27; x++) begin
            for (int y = 0; y < 27; y++) begin
                int xv = x, yv = y;
                ap = '0; an = '0; bp = '0; bn = '0;
                for (int k = 0; k < NB; k++) begin
                    ap[k] = (xv % 3 == 1); an[k] = (xv % 3 == 2);
                    bp[k] = (yv % 3 == 1); bn[k] = (yv % 3 == 2);
                    xv = xv / 3; yv = yv / 3;
                end
                drive(1, ap, an, bp, bn, 0, '0, '0, "R3 exhaustive");
            end
        end

        // R3 random at sixteen digits
        for (int r = 0; r < 1500; r++) begin
            rnd_op(ap, an, NA);
            rnd_op(bp, bn, NA);
            drive(0, ap, an, bp, bn, 0, '0, '0, "R3 random");
        end

        // R5 locality: change digit 0, upper digits stay put
        for (int r = 0; r < 40; r++) begin
            rnd_op(ap, an, NA);
            rnd_op(bp, bn, NA);
            drive(0, ap, an, bp, bn, 0, '0, '0, "R5 base");
            @(negedge clk); #1;
            keep_p = s0p; keep_n = s0n;
            ap[0] = ~ap[0] & ~an[0];
            an[0] = 1'b0;
            if (r % 2 == 1) begin
                an[0] = ~ap[0];
            end
            drive(0, ap, an, bp, bn, 0, '0, '0, "R5 changed");
            @(negedge clk); #1;
            check(s0p[NA:3] == keep_p[NA:3] && s0n[NA:3] == keep_n[NA:3],
                  "R5 upper digits unchanged",
                  longint'({s0p[NA:3], s0n[NA:3]}), longint'({keep_p[NA:3], keep_n[NA:3]}));
        end

        @(posedge clk);
        @(negedge clk); #1;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule